// File: doc/BRIEF.md
# Password Program and Unlock Unit

This unit holds an eight-byte (64-bit) password and carries out the three password operations available while the command sequencer has the password mode open: programming single bytes, reading bytes back, and presenting the whole password to release the persistent protection lock. The sequencer passes in decoded write and read cycles, each with an address, a data byte and a one-cycle strobe. The unit answers reads with registered data and a valid strobe. After a correct unlock frame it raises a single-cycle unlock pulse.

A byte is programmed by a two-write pair. The first write carries the program command at any address. The second write carries the byte itself at its password address. As in flash, programming can only clear bits. The unlock frame is eleven writes in a fixed order: a two-byte header, the eight password bytes at their own addresses in ascending order, and a closing command. A frame that breaks this order, or that carries any wrong byte, does not unlock. It sets a sticky fail flag, which can be read at a status address.

Top module: `pwu_top`

## Requirements
- R1: After reset every password byte reads FF, the status read returns 00 and unlockPulse is low.
- R2: While modeActive is low, writes have no effect and every read returns 00.
- R3: A write of A0 (any address) followed directly by a write at address k (0..7) stores old AND data into byte k. If that second write is at an address of 8 or more, it is discarded.
- R4: A write at a password address that is not directly preceded by the A0 write leaves the password unchanged.
- R5: A read at address k (0..7) returns byte k on rdData, with rdValid high in the cycle after rdStb. Bytes can be read in any order.
- R6: The whole address is decoded. A read at any address other than 00..08 returns 00.
- R7: A read at address 08 returns the fail flag in bit 0, with all other bits 0.
- R8: While protEn is high, reads at 00..07 return FF.
- R9: The write sequence 25@00, 03@00, the stored bytes at 00..07 in order, then 29@00 raises unlockPulse for exactly the one cycle after the last write, and clears the fail flag.
- R10: A complete frame that carries one or more wrong password bytes does not unlock and sets the fail flag.
- R11: A malformed frame (wrong header byte, or a byte at an address out of order) sets the fail flag and restarts frame recognition. A later correct frame unlocks.
- R12: Dropping modeActive in the middle of a frame aborts the frame without unlocking and without setting the fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeActive | input | 1 | Password mode is entered |
| protEn | input | 1 | Password protect enable; masks password reads |
| wrStb | input | 1 | Write cycle strobe |
| rdStb | input | 1 | Read cycle strobe |
| addr | input | ADDR_W (8) | Cycle address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | Read data valid, one cycle after rdStb |
| unlockPulse | output | 1 | One-cycle lock release |

## Verification
The bench uses the default parameters: eight password bytes, an 8-bit address and the status register at 08. With an 8-bit address the bench can reach alias addresses such as 13 and FF, which a partial decode would map onto password bytes. It can also reach discarded program targets above the password range. The bench programs one byte twice to show the AND behaviour, and it drives frames that break at the header, in the middle of the bytes, and through a mode drop.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_UNL_A = 8'h25;
  localparam logic [7:0] CMD_UNL_B = 8'h03;
  localparam logic [7:0] CMD_UNL_C = 8'h29;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_HDR,
    S_BYTES,
    S_END
  } pwuState_t;

  // strobes from control to datapath; idx sized for up to 256 bytes
  typedef struct packed {
    logic       progEn;
    logic       clrMatch;
    logic       cmpEn;
    logic [7:0] idx;
  } pwuStrb_t;
endpackage

// File: rtl/pwu_dpath.sv
module pwu_dpath
  import pwu_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwuStrb_t          strb,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              modeActive,
  input  logic              protEn,
  input  logic              failFlag,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              allMatch
);
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [7:0] pwMem [NUM_BYTES];
  logic [IDX_W-1:0] stbIdx;
  logic [IDX_W-1:0] rdIdx;
  logic inRange;
  logic [7:0] rdNext;

  assign stbIdx  = strb.idx[IDX_W-1:0];
  assign rdIdx   = addr[IDX_W-1:0];
  assign inRange = addr < ADDR_W'(NUM_BYTES);

  generate
    for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          pwMem[g] <= 8'hFF;
        else if (strb.progEn && stbIdx == IDX_W'(g))
          pwMem[g] <= pwMem[g] & wrData;
      end
      // R3: programming never sets a bit
      a_r3_no_set_bits: assert property (@(posedge clk) disable iff (!rstN)
        (pwMem[g] & ~$past(pwMem[g])) == 8'h00);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      allMatch <= 1'b1;
    else if (strb.clrMatch)
      allMatch <= 1'b1;
    else if (strb.cmpEn)
      allMatch <= allMatch && (wrData == pwMem[stbIdx]);
  end

  always_comb begin
    rdNext = 8'h00;
    if (modeActive) begin
      if (inRange)
        rdNext = protEn ? 8'hFF : pwMem[rdIdx];
      else if (addr == STATUS_ADDR)
        rdNext = {7'b0, failFlag};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 8'h00;
    end else begin
      rdValid <= rdStb;
      if (rdStb)
        rdData <= rdNext;
    end
  end

  a_r5_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> rdValid);
  a_r8_protect_ff: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && modeActive && protEn && inRange) |=> rdData == 8'hFF);
  a_r2_closed_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !modeActive) |=> rdData == 8'h00);
endmodule

// File: rtl/pwu_ctrl.sv
module pwu_ctrl
  import pwu_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeActive,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              allMatch,
  output pwuStrb_t          strb,
  output logic              failFlag,
  output logic              unlockPulse
);
  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  pwuState_t state, stateNext;
  logic [IDX_W-1:0] cnt, cntNext;
  logic pulseNext, setFail, clrFail;
  logic atZero;

  assign atZero = addr == '0;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    pulseNext = 1'b0;
    setFail   = 1'b0;
    clrFail   = 1'b0;
    strb      = '0;
    if (!modeActive) begin
      stateNext = S_IDLE;
      cntNext   = '0;
    end else if (wrStb) begin
      unique case (state)
        S_IDLE: begin
          if (wrData == CMD_PROG)
            stateNext = S_PROG;
          else if (wrData == CMD_UNL_A && atZero) begin
            stateNext     = S_HDR;
            strb.clrMatch = 1'b1;
          end
        end
        S_PROG: begin
          stateNext = S_IDLE;
          if (addr < ADDR_W'(NUM_BYTES)) begin
            strb.progEn = 1'b1;
            strb.idx    = 8'(addr[IDX_W-1:0]);
          end
        end
        S_HDR: begin
          if (wrData == CMD_UNL_B && atZero) begin
            stateNext = S_BYTES;
            cntNext   = '0;
          end else begin
            stateNext = S_IDLE;
            setFail   = 1'b1;
          end
        end
        S_BYTES: begin
          if (addr == ADDR_W'(cnt)) begin
            strb.cmpEn = 1'b1;
            strb.idx   = 8'(cnt);
            if (cnt == LAST_IDX) begin
              stateNext = S_END;
              cntNext   = '0;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end else begin
            stateNext = S_IDLE;
            cntNext   = '0;
            setFail   = 1'b1;
          end
        end
        S_END: begin
          stateNext = S_IDLE;
          if (wrData == CMD_UNL_C && atZero && allMatch) begin
            pulseNext = 1'b1;
            clrFail   = 1'b1;
          end else begin
            setFail = 1'b1;
          end
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      cnt         <= '0;
      unlockPulse <= 1'b0;
      failFlag    <= 1'b0;
    end else begin
      state       <= stateNext;
      cnt         <= cntNext;
      unlockPulse <= pulseNext;
      if (setFail)
        failFlag <= 1'b1;
      else if (clrFail)
        failFlag <= 1'b0;
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    unlockPulse |=> !unlockPulse);
  a_r10_fail_only_clears_on_unlock: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failFlag) |-> unlockPulse);
  a_r12_no_unlock_outside_mode: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> !unlockPulse);
  a_r9_pulse_needs_close: assert property (@(posedge clk) disable iff (!rstN)
    unlockPulse |-> $past(wrStb && wrData == CMD_UNL_C));
endmodule

// File: rtl/pwu_top.sv
module pwu_top
  import pwu_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeActive,
  input  logic              protEn,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              unlockPulse
);
  pwuStrb_t strb;
  logic failFlag;
  logic allMatch;

  pwu_ctrl #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .modeActive(modeActive), .wrStb(wrStb),
    .addr(addr), .wrData(wrData), .allMatch(allMatch), .strb(strb),
    .failFlag(failFlag), .unlockPulse(unlockPulse)
  );

  pwu_dpath #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .addr(addr),
    .rdStb(rdStb), .modeActive(modeActive), .protEn(protEn),
    .failFlag(failFlag), .rdData(rdData), .rdValid(rdValid), .allMatch(allMatch)
  );
endmodule

// File: tb/tb_pwu_top.sv
module tb_pwu_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeActive = 1'b0;
  logic protEn = 1'b0;
  logic wrStb = 1'b0;
  logic rdStb = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic unlockPulse;

  int checks = 0;
  int fails = 0;
  logic [7:0] expQ [$];
  string tagQ [$];
  logic [7:0] pwModel [8];

  always #5 clk = ~clk;

  pwu_top dut (
    .clk(clk), .rstN(rstN), .modeActive(modeActive), .protEn(protEn),
    .wrStb(wrStb), .rdStb(rdStb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .unlockPulse(unlockPulse)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wrCyc(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStb = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  // driver: pushes the expected byte, then issues the read
  task automatic rdCyc(input logic [7:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStb = 1'b1; addr = a;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    wrCyc(8'h11, 8'hA0);
    wrCyc(a, d);
    if (a < 8) pwModel[a[2:0]] = pwModel[a[2:0]] & d;
  endtask

  // full frame; badIdx < 8 corrupts that byte; result checked right after close
  task automatic unlockFrame(input int badIdx, input logic expPulse, input string tag);
    wrCyc(8'h00, 8'h25);
    wrCyc(8'h00, 8'h03);
    for (int i = 0; i < 8; i++)
      wrCyc(8'(i), (i == badIdx) ? ~pwModel[i] : pwModel[i]);
    wrCyc(8'h00, 8'h29);
    check(tag, {7'b0, unlockPulse}, {7'b0, expPulse});
  endtask

  // monitor: pops and compares as read results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rdValid) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL unexpected read: got %02h expected none", rdData);
        end else begin
          check(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) pwModel[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pulse low", {7'b0, unlockPulse}, 8'h00);
    modeActive = 1'b1;
    for (int i = 0; i < 8; i++) rdCyc(8'(i), 8'hFF, "R1 erased byte");
    rdCyc(8'h08, 8'h00, "R1 status clear");

    // R2: mode closed
    modeActive = 1'b0;
    wrCyc(8'h05, 8'hA0);
    wrCyc(8'h03, 8'h12);
    rdCyc(8'h03, 8'h00, "R2 closed read");
    modeActive = 1'b1;
    rdCyc(8'h03, 8'hFF, "R2 closed write ignored");

    // R4: lone data write
    wrCyc(8'h02, 8'h5A);
    rdCyc(8'h02, 8'hFF, "R4 no program without A0");

    // R3: program in scattered order, one byte twice, one discarded target
    prog(8'h05, 8'h6B); prog(8'h00, 8'h13); prog(8'h07, 8'h7E);
    prog(8'h02, 8'h4C); prog(8'h04, 8'hF0); prog(8'h04, 8'h3C);
    prog(8'h01, 8'h59); prog(8'h06, 8'h0D); prog(8'h03, 8'h91);
    prog(8'h0A, 8'h00);
    rdCyc(8'h04, 8'h30, "R3 AND of two programs");
    for (int i = 7; i >= 0; i--) rdCyc(8'(i), pwModel[i], "R5 reverse order read");
    rdCyc(8'h0A, 8'h00, "R3 discarded target");

    // R6 full decode
    rdCyc(8'h13, 8'h00, "R6 alias 13");
    rdCyc(8'hFF, 8'h00, "R6 alias FF");

    // R9 good unlock
    unlockFrame(99, 1'b1, "R9 correct frame pulse");
    @(negedge clk);
    check("R9 pulse one cycle", {7'b0, unlockPulse}, 8'h00);
    rdCyc(8'h08, 8'h00, "R9 status after unlock");

    // R10 wrong byte
    unlockFrame(5, 1'b0, "R10 wrong byte no pulse");
    rdCyc(8'h08, 8'h01, "R10 fail flag set");
    rdCyc(8'h08, 8'h01, "R7 fail sticky");

    // R11 malformed: byte out of order, then bad header
    unlockFrame(99, 1'b1, "R11 clear before test");
    wrCyc(8'h00, 8'h25); wrCyc(8'h00, 8'h03);
    wrCyc(8'h00, pwModel[0]); wrCyc(8'h01, pwModel[1]);
    wrCyc(8'h03, pwModel[3]);
    rdCyc(8'h08, 8'h01, "R11 out of order fail");
    unlockFrame(99, 1'b1, "R11 recovery unlock");
    wrCyc(8'h00, 8'h25); wrCyc(8'h00, 8'h04);
    rdCyc(8'h08, 8'h01, "R11 bad header fail");
    unlockFrame(99, 1'b1, "R11 second recovery");
    rdCyc(8'h08, 8'h00, "R7 status cleared");

    // R12 mode drop mid frame
    wrCyc(8'h00, 8'h25); wrCyc(8'h00, 8'h03);
    for (int i = 0; i < 4; i++) wrCyc(8'(i), pwModel[i]);
    @(negedge clk); modeActive = 1'b0;
    @(negedge clk); modeActive = 1'b1;
    for (int i = 4; i < 8; i++) wrCyc(8'(i), pwModel[i]);
    wrCyc(8'h00, 8'h29);
    check("R12 aborted no pulse", {7'b0, unlockPulse}, 8'h00);
    rdCyc(8'h08, 8'h00, "R12 no fail on abort");

    // R8 protect
    protEn = 1'b1;
    for (int i = 0; i < 8; i++) rdCyc(8'(i), 8'hFF, "R8 masked read");
    rdCyc(8'h08, 8'h00, "R8 status still readable");
    protEn = 1'b0;
    rdCyc(8'h01, pwModel[1], "R8 unmasked again");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule